// File: doc/BRIEF.md
# Sense-Gated Descending Block Transfer Engine

The engine moves a block of words between memory and a peripheral device. Software hands it four things on a start pulse: a start address, a word count, a direction and a function code. For each word, the engine first polls the device with a sense request carrying the function code. It moves nothing until the device answers true. Each true answer moves exactly one word. The address then steps down by one and the remaining count drops by one, so the block travels from its highest address to its lowest.

In the input direction, the device word is written straight into memory in the cycle the device is read. In the output direction, memory is read first and the word appears at the device one cycle later. The memory port has one cycle of read latency.

A block cannot be interrupted. An inhibit output stays high from the cycle after the start pulse until the done cycle, so the surrounding interrupt logic holds off acceptance for that span. A block whose word count is zero finishes at once and moves nothing.

Top module: `sense_blk_xfer`

## Requirements
- R1: After reset the engine is idle. busy_o, done_o, int_inhibit_o, sense_req_o, mem_req_o, dev_rd_o and dev_wr_o are all low.
- R2: start_i is taken only while idle. A start pulse during a block changes neither the latched function code, nor the addresses, nor the number of words moved.
- R3: While sense_req_o is high and sense_resp_i is low, the engine keeps waiting and drives no memory or device strobe. The address and remaining count it holds do not change.
- R4: Each cycle with sense_req_o and sense_resp_i both high is followed by exactly one word transfer. The number of true responses in a block equals its word count.
- R5: Transfer k of a block (k = 0, 1, ...) uses memory address start_addr_i - k. Addresses strictly decrease across the block.
- R6: Direction 0 (input): in the cycle dev_rd_o is high, mem_req_o and mem_we_o are high and mem_wdata_o equals dev_data_i.
- R7: Direction 1 (output): a memory read (mem_req_o high, mem_we_o low) is followed in the next cycle by dev_wr_o, with dev_data_o equal to the word memory returned for that address.
- R8: dev_fc_o during every transfer, and sense_fc_o during every sense request, equal the func_i latched at start.
- R9: After the last word, done_o is high for exactly one cycle. That cycle follows the final transfer cycle, and then the engine is idle again.
- R10: A start with count_i equal to 0 raises done_o in the very next cycle, with no sense request and no transfer.
- R11: int_inhibit_o is high from the cycle after the accepted start through the done cycle, and low in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken while idle |
| dir_i | input | 1 | 0 = device to memory, 1 = memory to device |
| start_addr_i | input | AW | Highest (first) address of the block |
| count_i | input | CW | Number of words |
| func_i | input | FW | Function code for sense and transfer |
| sense_req_o | output | 1 | Sense request to the device |
| sense_fc_o | output | FW | Function code sent with the sense request |
| sense_resp_i | input | 1 | True sense response |
| dev_rd_o | output | 1 | Read strobe: take a word from the device |
| dev_wr_o | output | 1 | Write strobe: hand a word to the device |
| dev_fc_o | output | FW | Function code sent with the transfer |
| dev_data_i | input | DW | Word from the device |
| dev_data_o | output | DW | Word to the device |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, one cycle after the request |
| busy_o | output | 1 | A block is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| int_inhibit_o | output | 1 | Holds off interrupt acceptance |

## Verification
Several rules are checked on every cycle. A waiting engine stays quiet and holds its address. A true response always leads to a transfer. Successive transfers step down by exactly one address, and a read is followed by a device write. Done lasts one cycle with the inhibit still high. The function code stays fixed through a block, even when a start pulse arrives in the middle of it. Other behaviour only the bench scenarios can show: the data matching memory contents, the total number of words equalling the requested count, the zero-count shortcut, and correct operation under varied response patterns, all checked through a scoreboard of expected addresses and data.

// File: rtl/sbx_pkg.sv
package sbx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SENSE = 3'd1,
    ST_MEM   = 3'd2,
    ST_PUSH  = 3'd3,
    ST_FIN   = 3'd4
  } sbx_state_e;

  typedef enum logic {
    DIR_IN  = 1'b0,
    DIR_OUT = 1'b1
  } sbx_dir_e;
endpackage

// File: rtl/sbx_cursor.sv
module sbx_cursor #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] cnt_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  localparam logic [CW-1:0] CntOne = CW'(1);

  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      cnt_q  <= cnt_i;
    end else if (step_i) begin
      addr_q <= addr_q - AW'(1);
      cnt_q  <= cnt_q - CntOne;
    end
  end

  assign addr_o = addr_q;
  assign last_o = (cnt_q == CntOne);
endmodule

// File: rtl/sbx_ctrl.sv
module sbx_ctrl
  import sbx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic start_zero_i,
  input  logic dir_q_i,
  input  logic sense_resp_i,
  input  logic last_i,
  output logic load_o,
  output logic step_o,
  output logic sense_req_o,
  output logic mem_req_o,
  output logic mem_we_o,
  output logic dev_rd_o,
  output logic dev_wr_o,
  output logic busy_o,
  output logic done_o
);
  sbx_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  logic in_dir;
  assign in_dir = (dir_q_i == DIR_IN);

  always_comb begin
    state_d     = state_q;
    load_o      = 1'b0;
    step_o      = 1'b0;
    sense_req_o = 1'b0;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    dev_rd_o    = 1'b0;
    dev_wr_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          state_d = start_zero_i ? ST_FIN : ST_SENSE;
        end
      end
      ST_SENSE: begin
        sense_req_o = 1'b1;
        if (sense_resp_i) state_d = ST_MEM;
      end
      ST_MEM: begin
        mem_req_o = 1'b1;
        if (in_dir) begin
          // device word lands in memory this cycle
          mem_we_o = 1'b1;
          dev_rd_o = 1'b1;
          step_o   = 1'b1;
          state_d  = last_i ? ST_FIN : ST_SENSE;
        end else begin
          state_d = ST_PUSH;
        end
      end
      ST_PUSH: begin
        dev_wr_o = 1'b1;
        step_o   = 1'b1;
        state_d  = last_i ? ST_FIN : ST_SENSE;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_FIN);
endmodule

// File: rtl/sense_blk_xfer.sv
module sense_blk_xfer
  import sbx_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int FW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          dir_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [CW-1:0] count_i,
  input  logic [FW-1:0] func_i,
  output logic          sense_req_o,
  output logic [FW-1:0] sense_fc_o,
  input  logic          sense_resp_i,
  output logic          dev_rd_o,
  output logic          dev_wr_o,
  output logic [FW-1:0] dev_fc_o,
  input  logic [DW-1:0] dev_data_i,
  output logic [DW-1:0] dev_data_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          int_inhibit_o
);
  logic          load, step, last;
  logic          dir_q;
  logic [FW-1:0] fc_q;
  logic [AW-1:0] addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= DIR_IN;
      fc_q  <= '0;
    end else if (load) begin
      dir_q <= dir_i;
      fc_q  <= func_i;
    end
  end

  sbx_cursor #(.AW(AW), .CW(CW)) u_cursor (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .addr_i (start_addr_i),
    .cnt_i  (count_i),
    .addr_o (addr),
    .last_o (last)
  );

  sbx_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .start_zero_i (count_i == '0),
    .dir_q_i      (dir_q),
    .sense_resp_i (sense_resp_i),
    .last_i       (last),
    .load_o       (load),
    .step_o       (step),
    .sense_req_o  (sense_req_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .dev_rd_o     (dev_rd_o),
    .dev_wr_o     (dev_wr_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  assign sense_fc_o    = fc_q;
  assign dev_fc_o      = fc_q;
  assign mem_addr_o    = addr;
  assign mem_wdata_o   = dev_data_i;
  assign dev_data_o    = mem_rdata_i;
  assign int_inhibit_o = busy_o;
endmodule

// File: rtl/sbx_checker.sv
module sbx_checker #(
  parameter int AW = 16,
  parameter int FW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          sense_req_o,
  input logic [FW-1:0] sense_fc_o,
  input logic          sense_resp_i,
  input logic          dev_rd_o,
  input logic          dev_wr_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          int_inhibit_o
);
  logic          have_prev;
  logic [AW-1:0] prev_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_prev <= 1'b0;
      prev_addr <= '0;
    end else if (done_o) begin
      have_prev <= 1'b0;
    end else if (mem_req_o) begin
      have_prev <= 1'b1;
      prev_addr <= mem_addr_o;
    end
  end

  a_r3_wait_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_req_o |-> !mem_req_o && !dev_rd_o && !dev_wr_o);

  a_r3_wait_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_req_o && !sense_resp_i) |=> sense_req_o && $stable(mem_addr_o));

  a_r4_resp_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_req_o && sense_resp_i) |=> mem_req_o);

  a_r5_descend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && have_prev) |-> mem_addr_o == prev_addr - AW'(1));

  a_r6_in_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rd_o |-> mem_req_o && mem_we_o);

  a_r7_read_then_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> dev_wr_o);

  a_r2_fc_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(sense_fc_o));

  a_r2_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && start_i) |=> busy_o);

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  a_r11_inhibit_span: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> int_inhibit_o);

  a_r11_inhibit_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !int_inhibit_o);
endmodule

bind sense_blk_xfer sbx_checker #(.AW(AW), .FW(FW)) u_sbx_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .sense_req_o   (sense_req_o),
  .sense_fc_o    (sense_fc_o),
  .sense_resp_i  (sense_resp_i),
  .dev_rd_o      (dev_rd_o),
  .dev_wr_o      (dev_wr_o),
  .mem_req_o     (mem_req_o),
  .mem_we_o      (mem_we_o),
  .mem_addr_o    (mem_addr_o),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .int_inhibit_o (int_inhibit_o)
);

// File: tb/sense_blk_xfer_bench.sv
module sense_blk_xfer_bench;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int FW = 3;
  localparam logic [DW-1:0] KEY = 16'h5A3C;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          dir_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic [CW-1:0] count_i = '0;
  logic [FW-1:0] func_i = '0;
  logic          sense_req_o, sense_resp_i;
  logic [FW-1:0] sense_fc_o, dev_fc_o;
  logic          dev_rd_o, dev_wr_o, mem_req_o, mem_we_o;
  logic [DW-1:0] dev_data_i, dev_data_o, mem_wdata_o;
  logic [DW-1:0] mem_rdata_i = '0;
  logic [AW-1:0] mem_addr_o;
  logic          busy_o, done_o, int_inhibit_o;

  always #4 clk_i = ~clk_i;

  sense_blk_xfer #(.AW(AW), .DW(DW), .CW(CW), .FW(FW)) u_sense_blk_xfer (.*);

  int unsigned cyc = 0;
  int          resp_mode = 0;
  int          n_checks = 0;
  int          n_fail = 0;
  int          xfer_cnt = 0;
  int          resp_cnt = 0;
  logic [FW-1:0] blk_fc = '0;
  logic [AW-1:0] exp_q[$];

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (mem_req_o && !mem_we_o) mem_rdata_i <= mem_addr_o ^ KEY;
  end

  assign dev_data_i = {cyc[7:0], 8'hC3};
  assign sense_resp_i = sense_req_o &&
    ((resp_mode == 0) || (resp_mode == 1 && cyc[0]) || (resp_mode == 2 && cyc[1:0] == 2'd3));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected addresses as transfers appear
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (sense_req_o) begin
        check(sense_fc_o == blk_fc, "R8", sense_fc_o, blk_fc);
        if (sense_resp_i) resp_cnt++;
        else check(!mem_req_o && !dev_rd_o && !dev_wr_o, "R3",
                   {mem_req_o, dev_rd_o, dev_wr_o}, 0);
      end
      if (dev_rd_o || dev_wr_o) begin
        xfer_cnt++;
        check(dev_fc_o == blk_fc, "R8", dev_fc_o, blk_fc);
        if (exp_q.size() == 0) check(1'b0, "R4", xfer_cnt, 0);
        else begin
          logic [AW-1:0] ea;
          ea = exp_q.pop_front();
          if (dev_rd_o) begin
            check(mem_req_o && mem_we_o && mem_addr_o == ea, "R5", mem_addr_o, ea);
            check(mem_wdata_o == dev_data_i, "R6", mem_wdata_o, dev_data_i);
          end else begin
            check(dev_data_o == (ea ^ KEY), "R7", dev_data_o, ea ^ KEY);
          end
        end
      end
    end
  end

  task automatic run_block(input bit dir, input logic [AW-1:0] addr, input int cnt,
                           input logic [FW-1:0] fc, input int mode, input bit poke);
    int guard;
    @(negedge clk_i);
    resp_mode = mode;
    xfer_cnt = 0;
    resp_cnt = 0;
    blk_fc = fc;
    for (int k = 0; k < cnt; k++) exp_q.push_back(addr - AW'(k));
    dir_i = dir; start_addr_i = addr; count_i = CW'(cnt); func_i = fc; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(int_inhibit_o == 1'b1, "R11", int_inhibit_o, 1);
    if (cnt == 0) begin
      check(done_o == 1'b1 && !sense_req_o && !mem_req_o, "R10", done_o, 1);
    end
    if (poke && cnt > 1) begin
      // mid-block start with different parameters must be ignored
      start_i = 1'b1; func_i = ~fc; start_addr_i = 16'h0100; count_i = 3; dir_i = ~dir;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    guard = 0;
    while (!done_o && guard < 2000) begin
      @(negedge clk_i);
      guard++;
    end
    check(done_o == 1'b1, "R9", done_o, 1);
    check(xfer_cnt == cnt, "R9", xfer_cnt, cnt);
    check(resp_cnt == cnt, "R4", resp_cnt, cnt);
    check(exp_q.size() == 0, poke ? "R2" : "R5", exp_q.size(), 0);
    check(int_inhibit_o == 1'b1, "R11", int_inhibit_o, 1);
    @(negedge clk_i);
    check(!done_o && !busy_o && !int_inhibit_o, "R11", {done_o, busy_o, int_inhibit_o}, 0);
    exp_q.delete();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !done_o && !int_inhibit_o && !sense_req_o && !mem_req_o
          && !dev_rd_o && !dev_wr_o, "R1", busy_o, 0);
    run_block(1'b0, 16'h0040, 5, 3'd2, 0, 1'b0);   // R6 input, always ready
    run_block(1'b1, 16'h0080, 6, 3'd5, 0, 1'b0);   // R7 output
    run_block(1'b0, 16'h0010, 4, 3'd1, 1, 1'b0);   // R3 alternating response
    run_block(1'b1, 16'h0020, 4, 3'd6, 2, 1'b0);   // R3 sparse response
    run_block(1'b0, 16'h0000, 0, 3'd4, 0, 1'b0);   // R10 zero count
    run_block(1'b1, 16'h0300, 7, 3'd3, 1, 1'b1);   // R2 start ignored
    run_block(1'b0, 16'h0002, 5, 3'd7, 2, 1'b0);   // R5 wraps below zero
    run_block(1'b1, 16'h0050, 1, 3'd0, 0, 1'b0);   // R9 single word
    finish_run();
  end

  initial begin
    wait (cyc > 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    finish_run();
  end
endmodule